// File: doc/BRIEF.md
# Stream Command Status Responder

This block sits beside the receive path of a streaming endpoint. Upstream logic has already decoded stream command messages into a source endpoint ID, an opcode, a 64-bit byte count and a 40-bit packet count. The block answers every such command with one status message, which it presents on a valid/ready handshake. The status message carries this endpoint's ID, a status code, the buffer capacities, the response sequence number and the two running transfer counters.

The transfer counters follow every packet the endpoint accepts, command packets included, through a one-cycle acceptance strobe and the packet's length in bytes. The byte counter advances in whole bus words, because that is the granularity of the endpoint's buffers. The three opcodes differ only in what they do to the counters before the reply is built. An initialise command clears the counters and the sequence number. A ping reports the counters as they stand. A resynchronise command loads both counters with the values the command carries.

Top module: `strm_status_resp`

## Requirements
- R1: After a synchronous active-low reset, no reply is pending and `cmd_ready` is high. The counters and the sequence number are zero, so a ping issued right after reset reports zero counts and sequence 0. A reset produces no reply.
- R2: Each accepted command (`cmd_valid` and `cmd_ready` both high on a clock edge) produces exactly one reply, and `rsp_valid` is high on the following cycle. `cmd_ready` stays low while a reply is pending, so a command presented during that time is not taken.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and every reply field holds its value.
- R4: An initialise command (opcode 0) clears both transfer counters and the sequence number before the reply is built. Its reply carries zero counts and sequence 0.
- R5: A resynchronise command (opcode 2) loads the byte counter from `cmd_nbytes` and the packet counter from `cmd_npkts`. Its reply reports those same values.
- R6: A ping (opcode 1) leaves the counters unchanged and reports their current values.
- R7: The sequence number of each reply is one more than that of the previous reply, unless the command is an initialise.
- R8: A reply is sent to the command's source ID (`rsp_dst_epid`), and its own source ID is `self_epid`. The status is 0 (okay) for opcodes 0 to 2.
- R9: Opcode 3 produces a reply with status 1 (command error). It leaves the counters unchanged, and its sequence number still advances.
- R10: `rsp_cap_bytes` equals 2^(MTU+1) × (BUS_W/8) − 1, and `rsp_cap_pkts` equals 0xFFFFFF.
- R11: Each cycle with `pkt_valid` high adds one to the packet counter. It also adds `pkt_len` rounded up to a multiple of BUS_W/8 to the byte counter, so a length of 0 adds no bytes.
- R12: A packet strobe in the same cycle as an accepted command does not appear in that command's reply. It is added on top of the value the command leaves in the counters.
- R13: The byte counter wraps modulo 2^64 and the packet counter wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| self_epid | input | EPID_W | This endpoint's ID, placed in replies |
| cmd_valid | input | 1 | Decoded command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_src_epid | input | EPID_W | ID of the command's sender |
| cmd_op | input | 2 | Opcode: 0 init, 1 ping, 2 resync |
| cmd_nbytes | input | BCNT_W | Byte count carried by the command |
| cmd_npkts | input | PCNT_W | Packet count carried by the command |
| pkt_valid | input | 1 | One packet accepted by the endpoint this cycle |
| pkt_len | input | LEN_W | Length in bytes of that packet |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken by the consumer |
| rsp_dst_epid | output | EPID_W | Reply destination (the command's sender) |
| rsp_src_epid | output | EPID_W | Reply source (this endpoint) |
| rsp_status | output | ST_W | 0 okay, 1 command error |
| rsp_seq | output | SEQ_W | Reply sequence number |
| rsp_cap_bytes | output | BCNT_W | Buffer capacity in bytes |
| rsp_cap_pkts | output | PCNT_W | Buffer capacity in packets |
| rsp_xfer_bytes | output | BCNT_W | Byte transfer counter |
| rsp_xfer_pkts | output | PCNT_W | Packet transfer counter |

## Verification
The assertions check the following on every cycle:
- the handshake: one reply per accepted command, no acceptance while a reply waits, and a stalled reply held stable;
- the opcode effects that can be seen in the reply that follows: zero counts after an initialise and echoed counts after a resynchronise;
- routing of the two IDs, the error status for the unused opcode, and the constant capacities.

The accumulation of packet lengths in whole words, the sequence progression across many commands, the same-cycle packet-and-command ordering, counter wrap and the effect of a reset in mid-run depend on history. Only the bench's scenarios show these, by comparing reply contents against values worked out by hand.

// File: rtl/strm_status_pkg.sv
// Package: shared opcode and status encodings for the stream status responder,
// and the capacity formula. Assumes power-of-two bus widths.
package strm_status_pkg;

    localparam logic [1:0] OP_INIT   = 2'd0;
    localparam logic [1:0] OP_PING   = 2'd1;
    localparam logic [1:0] OP_RESYNC = 2'd2;

    localparam int ST_W = 4;
    localparam logic [ST_W-1:0] ST_OKAY   = 4'd0;
    localparam logic [ST_W-1:0] ST_CMDERR = 4'd1;

    // Byte capacity: 2^(mtu+1) words of bus_bits/8 bytes, minus one.
    function automatic logic [63:0] byte_capacity(input int bus_bits, input int mtu);
        return (64'd1 << (mtu + 1 + $clog2(bus_bits / 8))) - 64'd1;
    endfunction

endpackage

// File: rtl/strm_len_rounder.sv
// Rounds a packet length in bytes up to a whole number of bus words.
// Assumes BUS_W/8 is a power of two. The result is zero-extended to OUT_W.
module strm_len_rounder #(
    parameter int BUS_W = 64,
    parameter int LEN_W = 16,
    parameter int OUT_W = 64
) (
    input  logic [LEN_W-1:0] len_bytes,
    output logic [OUT_W-1:0] len_words_bytes
);
    localparam int BUS_BYTES = BUS_W / 8;
    localparam int SH        = $clog2(BUS_BYTES);
    localparam int SUM_W     = LEN_W + 1;

    logic [SUM_W-1:0] padded;

    generate
        if (SH == 0) begin : g_byte_bus
            // Purpose: a bus one byte wide needs no rounding.
            always_comb padded = {1'b0, len_bytes};
        end else begin : g_word_bus
            // Purpose: add word-size minus one, then clear the sub-word bits.
            always_comb begin
                padded = {1'b0, len_bytes} + SUM_W'(BUS_BYTES - 1);
                padded[SH-1:0] = '0;
            end
        end
    endgenerate

    // Purpose: widen to counter width.
    always_comb len_words_bytes = OUT_W'(padded);
endmodule

// File: rtl/strm_cmd_decode.sv
// Works out, for an accepted command, the counter and sequence values that the
// reply reports, and the reply's status. Purely combinational.
module strm_cmd_decode
    import strm_status_pkg::*;
#(
    parameter int BCNT_W = 64,
    parameter int PCNT_W = 40,
    parameter int SEQ_W  = 16
) (
    input  logic [1:0]        op,
    input  logic [BCNT_W-1:0] cmd_nbytes,
    input  logic [PCNT_W-1:0] cmd_npkts,
    input  logic [BCNT_W-1:0] cur_bytes,
    input  logic [PCNT_W-1:0] cur_pkts,
    input  logic [SEQ_W-1:0]  cur_seq,
    output logic [BCNT_W-1:0] base_bytes,
    output logic [PCNT_W-1:0] base_pkts,
    output logic [SEQ_W-1:0]  base_seq,
    output logic [ST_W-1:0]   status
);
    // Purpose: pick the base values per opcode.
    always_comb begin
        base_bytes = cur_bytes;
        base_pkts  = cur_pkts;
        base_seq   = cur_seq;
        status     = ST_OKAY;
        case (op)
            OP_INIT: begin
                base_bytes = '0;
                base_pkts  = '0;
                base_seq   = '0;
            end
            OP_RESYNC: begin
                base_bytes = cmd_nbytes;
                base_pkts  = cmd_npkts;
            end
            OP_PING: ;
            default: status = ST_CMDERR;
        endcase
    end
endmodule

// File: rtl/strm_xfer_counters.sv
// Holds the byte and packet transfer counters and the next reply sequence number.
// On a command, the counters restart from the decoded base values. A packet in the
// same cycle is added on top of that base. Counters wrap at their width.
module strm_xfer_counters #(
    parameter int BCNT_W = 64,
    parameter int PCNT_W = 40,
    parameter int SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  logic [BCNT_W-1:0] base_bytes,
    input  logic [PCNT_W-1:0] base_pkts,
    input  logic [SEQ_W-1:0]  base_seq,
    input  logic              pkt_fire,
    input  logic [BCNT_W-1:0] pkt_bytes,
    output logic [BCNT_W-1:0] cnt_bytes,
    output logic [PCNT_W-1:0] cnt_pkts,
    output logic [SEQ_W-1:0]  cnt_seq
);
    logic [BCNT_W-1:0] nxt_bytes;
    logic [PCNT_W-1:0] nxt_pkts;
    logic [SEQ_W-1:0]  nxt_seq;

    // Purpose: compute next counter values from the base and the packet increment.
    always_comb begin
        nxt_bytes = (cmd_fire ? base_bytes : cnt_bytes) + (pkt_fire ? pkt_bytes : '0);
        nxt_pkts  = (cmd_fire ? base_pkts  : cnt_pkts)  + PCNT_W'(pkt_fire);
        nxt_seq   = cmd_fire ? base_seq + SEQ_W'(1) : cnt_seq;
    end

    // Purpose: counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_bytes <= '0;
            cnt_pkts  <= '0;
            cnt_seq   <= '0;
        end else begin
            cnt_bytes <= nxt_bytes;
            cnt_pkts  <= nxt_pkts;
            cnt_seq   <= nxt_seq;
        end
    end
endmodule

// File: rtl/strm_reply_reg.sv
// Single-entry output register with valid/ready. Loads when asked and holds its
// data until the consumer takes it. Assumes the caller loads only when empty.
module strm_reply_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    // Purpose: fill on load, empty on handshake, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/strm_status_resp.sv
// Stream command status responder: answers each decoded stream command with one
// status reply and tracks the transfer counters from the packet strobe.
// Assumes commands arrive already decoded and that pkt_valid marks one accepted
// packet per cycle.
module strm_status_resp
    import strm_status_pkg::*;
#(
    parameter int BUS_W  = 64,
    parameter int MTU    = 10,
    parameter int EPID_W = 16,
    parameter int LEN_W  = 16,
    parameter int SEQ_W  = 16,
    parameter int BCNT_W = 64,
    parameter int PCNT_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EPID_W-1:0] self_epid,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [EPID_W-1:0] cmd_src_epid,
    input  logic [1:0]        cmd_op,
    input  logic [BCNT_W-1:0] cmd_nbytes,
    input  logic [PCNT_W-1:0] cmd_npkts,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [EPID_W-1:0] rsp_dst_epid,
    output logic [EPID_W-1:0] rsp_src_epid,
    output logic [ST_W-1:0]   rsp_status,
    output logic [SEQ_W-1:0]  rsp_seq,
    output logic [BCNT_W-1:0] rsp_cap_bytes,
    output logic [PCNT_W-1:0] rsp_cap_pkts,
    output logic [BCNT_W-1:0] rsp_xfer_bytes,
    output logic [PCNT_W-1:0] rsp_xfer_pkts
);
    localparam logic [63:0] CAP_BYTES = byte_capacity(BUS_W, MTU);
    localparam int RPL_W = 2 * EPID_W + ST_W + SEQ_W + BCNT_W + PCNT_W;

    logic              cmd_fire;
    logic [BCNT_W-1:0] pkt_bytes;
    logic [BCNT_W-1:0] cur_bytes, base_bytes;
    logic [PCNT_W-1:0] cur_pkts, base_pkts;
    logic [SEQ_W-1:0]  cur_seq, base_seq;
    logic [ST_W-1:0]   status;
    logic [RPL_W-1:0]  rpl_in, rpl_out;

    // Purpose: accept a command only when the reply slot is empty.
    always_comb begin
        cmd_ready = !rsp_valid;
        cmd_fire  = cmd_valid && cmd_ready;
    end

    strm_len_rounder #(.BUS_W(BUS_W), .LEN_W(LEN_W), .OUT_W(BCNT_W)) u_round (
        .len_bytes       (pkt_len),
        .len_words_bytes (pkt_bytes)
    );

    strm_cmd_decode #(.BCNT_W(BCNT_W), .PCNT_W(PCNT_W), .SEQ_W(SEQ_W)) u_dec (
        .op         (cmd_op),
        .cmd_nbytes (cmd_nbytes),
        .cmd_npkts  (cmd_npkts),
        .cur_bytes  (cur_bytes),
        .cur_pkts   (cur_pkts),
        .cur_seq    (cur_seq),
        .base_bytes (base_bytes),
        .base_pkts  (base_pkts),
        .base_seq   (base_seq),
        .status     (status)
    );

    strm_xfer_counters #(.BCNT_W(BCNT_W), .PCNT_W(PCNT_W), .SEQ_W(SEQ_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .base_bytes (base_bytes),
        .base_pkts  (base_pkts),
        .base_seq   (base_seq),
        .pkt_fire   (pkt_valid),
        .pkt_bytes  (pkt_bytes),
        .cnt_bytes  (cur_bytes),
        .cnt_pkts   (cur_pkts),
        .cnt_seq    (cur_seq)
    );

    // Purpose: pack the reply fields for the output register.
    always_comb rpl_in = {cmd_src_epid, self_epid, status, base_seq, base_bytes, base_pkts};

    strm_reply_reg #(.W(RPL_W)) u_rpl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_fire),
        .load_data (rpl_in),
        .out_ready (rsp_ready),
        .out_valid (rsp_valid),
        .out_data  (rpl_out)
    );

    // Purpose: unpack the held reply and drive the constant capacities.
    always_comb begin
        {rsp_dst_epid, rsp_src_epid, rsp_status, rsp_seq, rsp_xfer_bytes, rsp_xfer_pkts} = rpl_out;
        rsp_cap_bytes = BCNT_W'(CAP_BYTES);
        rsp_cap_pkts  = PCNT_W'(24'hFF_FFFF);
    end
endmodule

// File: rtl/strm_status_resp_chk.sv
// Checker for strm_status_resp: handshake, opcode effects seen in the following
// reply, ID routing, error status and capacities. Attached by bind below.
module strm_status_resp_chk #(
    parameter int BUS_W  = 64,
    parameter int MTU    = 10,
    parameter int EPID_W = 16,
    parameter int SEQ_W  = 16,
    parameter int BCNT_W = 64,
    parameter int PCNT_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EPID_W-1:0] self_epid,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [EPID_W-1:0] cmd_src_epid,
    input logic [1:0]        cmd_op,
    input logic [BCNT_W-1:0] cmd_nbytes,
    input logic [PCNT_W-1:0] cmd_npkts,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [EPID_W-1:0] rsp_dst_epid,
    input logic [EPID_W-1:0] rsp_src_epid,
    input logic [3:0]        rsp_status,
    input logic [SEQ_W-1:0]  rsp_seq,
    input logic [BCNT_W-1:0] rsp_cap_bytes,
    input logic [PCNT_W-1:0] rsp_cap_pkts,
    input logic [BCNT_W-1:0] rsp_xfer_bytes,
    input logic [PCNT_W-1:0] rsp_xfer_pkts
);
    localparam logic [BCNT_W-1:0] EXP_CAP = BCNT_W'(((64'd1 << (MTU + 1)) * (BUS_W / 8)) - 1);

    logic fire;
    always_comb fire = cmd_valid && cmd_ready;

    p_block_while_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    p_reply_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);

    p_hold_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_xfer_bytes) && $stable(rsp_xfer_pkts)
            && $stable(rsp_seq) && $stable(rsp_dst_epid) && $stable(rsp_status));

    p_init_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_op == 2'd0 |=> rsp_xfer_bytes == '0 && rsp_xfer_pkts == '0 && rsp_seq == '0);

    p_resync_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_op == 2'd2 |=> rsp_xfer_bytes == $past(cmd_nbytes) && rsp_xfer_pkts == $past(cmd_npkts));

    p_routing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_dst_epid == $past(cmd_src_epid) && rsp_src_epid == $past(self_epid));

    p_bad_op_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_op == 2'd3 |=> rsp_status == 4'd1);

    p_capacity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_cap_bytes == EXP_CAP && rsp_cap_pkts == PCNT_W'(24'hFF_FFFF));
endmodule

bind strm_status_resp strm_status_resp_chk #(
    .BUS_W(BUS_W), .MTU(MTU), .EPID_W(EPID_W), .SEQ_W(SEQ_W), .BCNT_W(BCNT_W), .PCNT_W(PCNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .self_epid      (self_epid),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_src_epid   (cmd_src_epid),
    .cmd_op         (cmd_op),
    .cmd_nbytes     (cmd_nbytes),
    .cmd_npkts      (cmd_npkts),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_dst_epid   (rsp_dst_epid),
    .rsp_src_epid   (rsp_src_epid),
    .rsp_status     (rsp_status),
    .rsp_seq        (rsp_seq),
    .rsp_cap_bytes  (rsp_cap_bytes),
    .rsp_cap_pkts   (rsp_cap_pkts),
    .rsp_xfer_bytes (rsp_xfer_bytes),
    .rsp_xfer_pkts  (rsp_xfer_pkts)
);

// File: tb/strm_status_resp_bench.sv
`timescale 1ns/1ps
// Bench for strm_status_resp: a vector table walked by one loop, then directed
// tests for same-cycle ordering, stalls, wrap and reset in mid-run.
module strm_status_resp_bench;
    localparam logic [15:0] SELF = 16'h0A5C;
    localparam logic [63:0] CAP_B = 64'd16383;   // 2^11 * 8 - 1
    localparam logic [39:0] CAP_P = 40'hFF_FFFF;

    typedef struct packed {
        logic        has_pkt;
        logic [15:0] len;
        logic [1:0]  op;
        logic [63:0] nb;
        logic [39:0] np;
        logic [63:0] eb;
        logic [39:0] ep;
        logic [15:0] es;
        logic [3:0]  st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 16'd0,  2'd1, 64'd0,     40'd0, 64'd0,      40'd0, 16'd0, 4'd0},
        '{1'b1, 16'd20, 2'd1, 64'd0,     40'd0, 64'd24,     40'd1, 16'd1, 4'd0},
        '{1'b1, 16'd8,  2'd0, 64'd0,     40'd0, 64'd0,      40'd0, 16'd0, 4'd0},
        '{1'b1, 16'd1,  2'd1, 64'd0,     40'd0, 64'd8,      40'd1, 16'd1, 4'd0},
        '{1'b0, 16'd0,  2'd2, 64'h1000,  40'd5, 64'h1000,   40'd5, 16'd2, 4'd0},
        '{1'b1, 16'd16, 2'd1, 64'd0,     40'd0, 64'h1010,   40'd6, 16'd3, 4'd0},
        '{1'b0, 16'd0,  2'd3, 64'd7,     40'd7, 64'h1010,   40'd6, 16'd4, 4'd1},
        '{1'b1, 16'd0,  2'd1, 64'd0,     40'd0, 64'h1010,   40'd7, 16'd5, 4'd0},
        '{1'b0, 16'd0,  2'd0, 64'd0,     40'd0, 64'd0,      40'd0, 16'd0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_src_epid = '0;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_nbytes = '0;
    logic [39:0] cmd_npkts = '0;
    logic        pkt_valid = 1'b0;
    logic [15:0] pkt_len = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [15:0] rsp_dst_epid, rsp_src_epid, rsp_seq;
    logic [3:0]  rsp_status;
    logic [63:0] rsp_cap_bytes, rsp_xfer_bytes;
    logic [39:0] rsp_cap_pkts, rsp_xfer_pkts;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    strm_status_resp u_strm_status_resp (
        .clk(clk), .rst_n(rst_n), .self_epid(SELF),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src_epid(cmd_src_epid),
        .cmd_op(cmd_op), .cmd_nbytes(cmd_nbytes), .cmd_npkts(cmd_npkts),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_dst_epid(rsp_dst_epid), .rsp_src_epid(rsp_src_epid), .rsp_status(rsp_status),
        .rsp_seq(rsp_seq), .rsp_cap_bytes(rsp_cap_bytes), .rsp_cap_pkts(rsp_cap_pkts),
        .rsp_xfer_bytes(rsp_xfer_bytes), .rsp_xfer_pkts(rsp_xfer_pkts)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_reply(input string tag, input logic [15:0] dst, input logic [63:0] eb,
                             input logic [39:0] ep, input logic [15:0] es, input logic [3:0] st);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_dst_epid !== dst || rsp_src_epid !== SELF ||
            rsp_xfer_bytes !== eb || rsp_xfer_pkts !== ep || rsp_seq !== es ||
            rsp_status !== st || rsp_cap_bytes !== CAP_B || rsp_cap_pkts !== CAP_P) begin
            errors++;
            $display("FAIL %s: actual v=%b dst=%h src=%h b=%h p=%h seq=%0d st=%0d cap=%h/%h expected v=1 dst=%h src=%h b=%h p=%h seq=%0d st=%0d cap=%h/%h",
                     tag, rsp_valid, rsp_dst_epid, rsp_src_epid, rsp_xfer_bytes, rsp_xfer_pkts,
                     rsp_seq, rsp_status, rsp_cap_bytes, rsp_cap_pkts,
                     dst, SELF, eb, ep, es, st, CAP_B, CAP_P);
        end
    endtask

    // One packet strobe, no command.
    task automatic send_pkt(input logic [15:0] len);
        @(negedge clk); pkt_valid = 1'b1; pkt_len = len;
        @(negedge clk); pkt_valid = 1'b0;
    endtask

    // Present a command for one cycle (optionally with a packet strobe beside it);
    // returns at the negedge where the reply is visible.
    task automatic send_cmd(input logic [1:0] op, input logic [63:0] nb, input logic [39:0] np,
                            input logic [15:0] src, input logic with_pkt, input logic [15:0] len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_nbytes = nb; cmd_npkts = np; cmd_src_epid = src;
        pkt_valid = with_pkt; pkt_len = len;
        @(negedge clk);
        cmd_valid = 1'b0; pkt_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] h_seq;
        logic [63:0] h_b;
        logic        stable_ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1 cmd_ready after reset", 64'(cmd_ready), 64'd1);

        // Table walk: R4 init, R5 resync, R6 ping, R7 seq, R8 ids, R9 bad op,
        // R10 capacity, R11 word-rounded lengths.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].has_pkt) send_pkt(VECS[i].len);
            send_cmd(VECS[i].op, VECS[i].nb, VECS[i].np, 16'h0100 + 16'(i), 1'b0, 16'd0);
            chk_reply($sformatf("R4/R5/R6/R7/R8/R9/R10/R11 vector %0d", i),
                      16'h0100 + 16'(i), VECS[i].eb, VECS[i].ep, VECS[i].es, VECS[i].st);
            @(negedge clk);
        end

        // R12: packet strobe in the command's own cycle is not in its reply.
        send_cmd(2'd1, 64'd0, 40'd0, 16'h0200, 1'b1, 16'd9);
        chk_reply("R12 same-cycle reply", 16'h0200, 64'd0, 40'd0, 16'd1, 4'd0);
        @(negedge clk);
        send_cmd(2'd1, 64'd0, 40'd0, 16'h0201, 1'b0, 16'd0);
        chk_reply("R12 packet added after", 16'h0201, 64'd16, 40'd1, 16'd2, 4'd0);
        @(negedge clk);

        // R3 and R2: stalled reply holds, and a command offered meanwhile is not taken.
        rsp_ready = 1'b0;
        send_cmd(2'd1, 64'd0, 40'd0, 16'h0300, 1'b0, 16'd0);
        chk("R2 cmd_ready low while pending", 64'(cmd_ready), 64'd0);
        h_seq = rsp_seq; h_b = rsp_xfer_bytes;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_src_epid = 16'h0666;
        stable_ok = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (rsp_valid !== 1'b1 || rsp_seq !== h_seq || rsp_xfer_bytes !== h_b ||
                rsp_dst_epid !== 16'h0300) stable_ok = 1'b0;
        end
        chk("R3 reply held while stalled", 64'(stable_ok), 64'd1);
        chk_reply("R3 held reply contents", 16'h0300, 64'd16, 40'd1, 16'd3, 4'd0);
        cmd_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        chk("R2 single reply per command", 64'(rsp_valid), 64'd0);
        send_cmd(2'd1, 64'd0, 40'd0, 16'h0301, 1'b0, 16'd0);
        chk_reply("R2 blocked init was ignored", 16'h0301, 64'd16, 40'd1, 16'd4, 4'd0);
        @(negedge clk);

        // R13: counters wrap at their widths.
        send_cmd(2'd2, 64'hFFFF_FFFF_FFFF_FFF8, 40'hFF_FFFF_FFFF, 16'h0400, 1'b0, 16'd0);
        chk_reply("R13 resync near top", 16'h0400, 64'hFFFF_FFFF_FFFF_FFF8, 40'hFF_FFFF_FFFF, 16'd5, 4'd0);
        @(negedge clk);
        send_pkt(16'd16);
        send_cmd(2'd1, 64'd0, 40'd0, 16'h0401, 1'b0, 16'd0);
        chk_reply("R13 wrapped counters", 16'h0401, 64'd8, 40'd0, 16'd6, 4'd0);
        @(negedge clk);

        // R1: reset in mid-run clears state and produces no reply.
        send_pkt(16'd40);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 no reply from reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no reply after reset release", 64'(rsp_valid), 64'd0);
        send_cmd(2'd1, 64'd0, 40'd0, 16'h0500, 1'b0, 16'd0);
        chk_reply("R1 ping after mid-run reset", 16'h0500, 64'd0, 40'd0, 16'd0, 4'd0);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule